// File: doc/BRIEF.md
# Display Storage Access Controller

This block sits between a small processor bus and the storage of an on-screen display unit. The processor reaches display storage through a 64-location window at the bottom of its address space. A page-select register chooses which of two display pages the window shows. The first page exposes 64 bytes of character memory. The second page exposes 16 more bytes of character memory, followed by five display control registers and the display-enable bit. A character bank register sits at a fixed address outside the window and does not depend on the page selection.

While the display-enable bit is set, the processor is locked out of the character memory, the five control registers and the bank register. Writes to these are dropped, and reads of them return zero. The enable bit stays writable at all times, so the lock can always be released. The display engine gets a combinational read port into the character memory, and the control register values appear on dedicated outputs.

Processor reads are registered. Data appears on `cpu_rdata` in the cycle after `cpu_rd` is sampled high, and the bus reads zero in any cycle that follows one without a read.

Top module: `dispacc_top`

## Requirements
- R1: After reset, every register is zero: page select, display enable, the five control registers, the bank register, every character byte and `cpu_rdata`.
- R2: When page-select bit 5 alone is set, window address A (00h–3Fh) reaches character byte A. When bit 6 alone is set, window address A (00h–0Fh) reaches character byte 64+A. A read returns the stored byte on `cpu_rdata` one cycle after `cpu_rd`.
- R3: A write to a character byte stores bit 6 as 0 and stores the other seven bits as written.
- R4: With bit 6 alone selected, offsets 10h, 11h, 12h, 13h and 14h are read/write registers driving `vstart`, `hstart`, `vspace`, `hspace` and `bgctl`.
- R5: Address EDh is the 8-bit bank register driving `charbank`, reachable under every page setting.
- R6: Address E8h is the page-select register. It can be read and written at all times. If bit 5 and bit 6 are both set or both clear, the window reaches no storage.
- R7: Offset 17h on page 6 holds the display enable. Only data bit 0 is kept, and it drives `disp_en`. It reads as 00h, and writes to it take effect whatever its current value.
- R8: While `disp_en` is 1, writes to character bytes, the five control registers and the bank register change nothing, and reads of them return 00h.
- R9: Window offsets on page 6 that map to nothing (15h, 16h, 18h–3Fh) and every other address outside the window, E8h and EDh read 00h and leave all storage unchanged when written.
- R10: `eng_char` shows character byte `eng_addr` without delay. Indexes at or above 80 give 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Processor address |
| cpu_wr | input | 1 | Write strobe, one write per cycle high |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| eng_addr | input | 7 | Display engine character index |
| eng_char | output | 8 | Character byte at `eng_addr` |
| vstart | output | 8 | Vertical start register |
| hstart | output | 8 | Horizontal start register |
| vspace | output | 8 | Vertical spacing register |
| hspace | output | 8 | Horizontal spacing register |
| bgctl | output | 8 | Background control register |
| charbank | output | 8 | Character bank register |
| disp_en | output | 1 | Display enable bit |

## Verification
The bench builds the block with its default parameters: a 64-location window, 16 extra bytes on the second page and 8-bit data. At that size, every one of the 80 character bytes, every window offset on page 6 and all 128 engine indexes can be swept in full. The sweeps run under each page-select setting and with the display enable both set and clear. Expected contents come from a bench-side model that applies the bit-6 masking arithmetically. After every batch of dropped or unmapped writes, the model is compared byte by byte against the engine port and the register outputs.

// File: rtl/dispacc_pkg.sv
package dispacc_pkg;

   // Storage targets an address can resolve to
   typedef enum logic [3:0] {
      TGT_NONE,
      TGT_RAM,
      TGT_VSTART,
      TGT_HSTART,
      TGT_VSPACE,
      TGT_HSPACE,
      TGT_BGCTL,
      TGT_ENABLE,
      TGT_BANK,
      TGT_PAGE
   } tgt_e;

   localparam int NUM_CTRL = 6;  // five display controls plus the bank register

   // Targets that the display enable locks against processor access
   function automatic logic tgt_locked(input tgt_e t);
      return (t == TGT_RAM)    || (t == TGT_VSTART) || (t == TGT_HSTART) ||
             (t == TGT_VSPACE) || (t == TGT_HSPACE) || (t == TGT_BGCTL)  ||
             (t == TGT_BANK);
   endfunction

   // Slot of a control target inside the control register bank
   function automatic int ctrl_slot(input tgt_e t);
      case (t)
         TGT_VSTART: return 0;
         TGT_HSTART: return 1;
         TGT_VSPACE: return 2;
         TGT_HSPACE: return 3;
         TGT_BGCTL:  return 4;
         TGT_BANK:   return 5;
         default:    return -1;
      endcase
   endfunction

endpackage

// File: rtl/dispacc_decode.sv
module dispacc_decode
   import dispacc_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                WIN_DEPTH  = 64,
   parameter int                HI_RAM     = 16,
   parameter int                RAM_AW     = 7,
   parameter logic [ADDR_W-1:0] PAGE_ADDR  = 'hE8,
   parameter logic [ADDR_W-1:0] BANK_ADDR  = 'hED,
   parameter int                OFS_VSTART = 16,
   parameter int                OFS_HSTART = 17,
   parameter int                OFS_VSPACE = 18,
   parameter int                OFS_HSPACE = 19,
   parameter int                OFS_BGCTL  = 20,
   parameter int                OFS_ENABLE = 23
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_lo,
   input  logic              sel_hi,
   output tgt_e              tgt,
   output logic [RAM_AW-1:0] ram_idx
);

   localparam int WIN_AW = $clog2(WIN_DEPTH);
   localparam logic [ADDR_W:0]   WIN_LIMIT = (ADDR_W+1)'(WIN_DEPTH);
   localparam logic [WIN_AW:0]   HI_LIMIT  = (WIN_AW+1)'(HI_RAM);
   localparam logic [WIN_AW-1:0] O_VST = WIN_AW'(OFS_VSTART);
   localparam logic [WIN_AW-1:0] O_HST = WIN_AW'(OFS_HSTART);
   localparam logic [WIN_AW-1:0] O_VSP = WIN_AW'(OFS_VSPACE);
   localparam logic [WIN_AW-1:0] O_HSP = WIN_AW'(OFS_HSPACE);
   localparam logic [WIN_AW-1:0] O_BG  = WIN_AW'(OFS_BGCTL);
   localparam logic [WIN_AW-1:0] O_EN  = WIN_AW'(OFS_ENABLE);
   localparam logic [RAM_AW-1:0] HI_BASE = RAM_AW'(WIN_DEPTH);

   logic              in_win;
   logic              only_lo;
   logic              only_hi;
   logic [WIN_AW-1:0] ofs;

   assign in_win  = {1'b0, addr} < WIN_LIMIT;
   assign only_lo = sel_lo & ~sel_hi;
   assign only_hi = sel_hi & ~sel_lo;
   assign ofs     = addr[WIN_AW-1:0];

   always_comb begin
      tgt     = TGT_NONE;
      ram_idx = '0;
      if (addr == PAGE_ADDR) begin
         tgt = TGT_PAGE;
      end else if (addr == BANK_ADDR) begin
         tgt = TGT_BANK;
      end else if (in_win && only_lo) begin
         tgt     = TGT_RAM;
         ram_idx = RAM_AW'(ofs);
      end else if (in_win && only_hi) begin
         if ({1'b0, ofs} < HI_LIMIT) begin
            tgt     = TGT_RAM;
            ram_idx = HI_BASE + RAM_AW'(ofs);
         end else if (ofs == O_VST) begin
            tgt = TGT_VSTART;
         end else if (ofs == O_HST) begin
            tgt = TGT_HSTART;
         end else if (ofs == O_VSP) begin
            tgt = TGT_VSPACE;
         end else if (ofs == O_HSP) begin
            tgt = TGT_HSPACE;
         end else if (ofs == O_BG) begin
            tgt = TGT_BGCTL;
         end else if (ofs == O_EN) begin
            tgt = TGT_ENABLE;
         end
      end
   end

endmodule

// File: rtl/dispacc_charram.sv
module dispacc_charram #(
   parameter int DEPTH    = 80,
   parameter int AW       = 7,
   parameter int DW       = 8,
   parameter int ZERO_BIT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] cpu_raddr,
   output logic [DW-1:0] cpu_rdata,
   input  logic [AW-1:0] eng_raddr,
   output logic [DW-1:0] eng_rdata
);

   localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << ZERO_BIT);
   localparam logic [AW:0]   LIMIT     = (AW+1)'(DEPTH);

   logic [DEPTH-1:0][DW-1:0] cell_vec;

   // One register per character byte; bit ZERO_BIT is never stored as 1
   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (waddr == AW'(i))) begin
            q <= wdata & KEEP_MASK;
         end
      end
      assign cell_vec[i] = q;
   end

   assign cpu_rdata = ({1'b0, cpu_raddr} < LIMIT) ? cell_vec[cpu_raddr] : '0;
   assign eng_rdata = ({1'b0, eng_raddr} < LIMIT) ? cell_vec[eng_raddr] : '0;

endmodule

// File: rtl/dispacc_ctrlregs.sv
module dispacc_ctrlregs #(
   parameter int NREG = 6,
   parameter int DW   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NREG-1:0]           we_vec,
   input  logic [DW-1:0]             wdata,
   output logic [NREG-1:0][DW-1:0]   q_vec
);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we_vec[k]) begin
            q <= wdata;
         end
      end
      assign q_vec[k] = q;
   end

endmodule

// File: rtl/dispacc_top.sv
module dispacc_top
   import dispacc_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                WIN_DEPTH  = 64,
   parameter int                HI_RAM     = 16,
   parameter int                RAM_AW     = $clog2(WIN_DEPTH + HI_RAM),
   parameter int                CODE_W     = 6,
   parameter int                ZERO_BIT   = 6,
   parameter int                PG_LO_BIT  = 5,
   parameter int                PG_HI_BIT  = 6,
   parameter logic [ADDR_W-1:0] PAGE_ADDR  = 'hE8,
   parameter logic [ADDR_W-1:0] BANK_ADDR  = 'hED,
   parameter int                OFS_VSTART = 16,
   parameter int                OFS_ENABLE = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [RAM_AW-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_char,
   output logic [DATA_W-1:0] vstart,
   output logic [DATA_W-1:0] hstart,
   output logic [DATA_W-1:0] vspace,
   output logic [DATA_W-1:0] hspace,
   output logic [DATA_W-1:0] bgctl,
   output logic [DATA_W-1:0] charbank,
   output logic              disp_en
);

   localparam int RAM_DEPTH = WIN_DEPTH + HI_RAM;
   localparam int WIN_AW    = $clog2(WIN_DEPTH);

   // Elaboration checks on the configuration
   if (CODE_W >= DATA_W || ZERO_BIT >= DATA_W || ZERO_BIT < CODE_W) begin : g_bad_code
      $error("dispacc_top: character code field does not fit the data width");
   end
   if (PG_LO_BIT >= DATA_W || PG_HI_BIT >= DATA_W || PG_LO_BIT == PG_HI_BIT) begin : g_bad_page
      $error("dispacc_top: page select bits invalid");
   end
   if ((1 << RAM_AW) < RAM_DEPTH) begin : g_bad_aw
      $error("dispacc_top: RAM_AW too narrow for character storage");
   end
   if (HI_RAM > OFS_VSTART || OFS_ENABLE < OFS_VSTART + 5 || OFS_ENABLE >= WIN_DEPTH) begin : g_bad_map
      $error("dispacc_top: page 6 layout overlaps or leaves the window");
   end
   if ((1 << WIN_AW) != WIN_DEPTH || WIN_DEPTH > (1 << ADDR_W)) begin : g_bad_win
      $error("dispacc_top: window depth must be a power of two within the address space");
   end

   tgt_e                     tgt;
   logic [RAM_AW-1:0]        ram_idx;
   logic [DATA_W-1:0]        page_q;
   logic                     ge_q;
   logic                     granted;
   logic                     ram_we;
   logic [NUM_CTRL-1:0]      ctrl_we;
   logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0]        ram_cpu_val;
   logic [DATA_W-1:0]        rd_val;
   logic [DATA_W-1:0]        rdata_q;

   dispacc_decode #(
      .ADDR_W     (ADDR_W),
      .WIN_DEPTH  (WIN_DEPTH),
      .HI_RAM     (HI_RAM),
      .RAM_AW     (RAM_AW),
      .PAGE_ADDR  (PAGE_ADDR),
      .BANK_ADDR  (BANK_ADDR),
      .OFS_VSTART (OFS_VSTART),
      .OFS_HSTART (OFS_VSTART + 1),
      .OFS_VSPACE (OFS_VSTART + 2),
      .OFS_HSPACE (OFS_VSTART + 3),
      .OFS_BGCTL  (OFS_VSTART + 4),
      .OFS_ENABLE (OFS_ENABLE)
   ) u_decode (
      .addr    (cpu_addr),
      .sel_lo  (page_q[PG_LO_BIT]),
      .sel_hi  (page_q[PG_HI_BIT]),
      .tgt     (tgt),
      .ram_idx (ram_idx)
   );

   // The enable lock applies only to the protected storage
   assign granted = !(tgt_locked(tgt) && ge_q);
   assign ram_we  = cpu_wr && granted && (tgt == TGT_RAM);

   always_comb begin
      ctrl_we = '0;
      for (int k = 0; k < NUM_CTRL; k++) begin
         if (cpu_wr && granted && (ctrl_slot(tgt) == k)) begin
            ctrl_we[k] = 1'b1;
         end
      end
   end

   dispacc_charram #(
      .DEPTH    (RAM_DEPTH),
      .AW       (RAM_AW),
      .DW       (DATA_W),
      .ZERO_BIT (ZERO_BIT)
   ) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ram_we),
      .waddr     (ram_idx),
      .wdata     (cpu_wdata),
      .cpu_raddr (ram_idx),
      .cpu_rdata (ram_cpu_val),
      .eng_raddr (eng_addr),
      .eng_rdata (eng_char)
   );

   dispacc_ctrlregs #(
      .NREG (NUM_CTRL),
      .DW   (DATA_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_vec (ctrl_we),
      .wdata  (cpu_wdata),
      .q_vec  (ctrl_q)
   );

   // Page select and display enable are never locked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ge_q   <= 1'b0;
      end else if (cpu_wr) begin
         if (tgt == TGT_PAGE)   page_q <= cpu_wdata;
         if (tgt == TGT_ENABLE) ge_q   <= cpu_wdata[0];
      end
   end

   // Read selection; the enable bit is write-only and falls to the default
   always_comb begin
      rd_val = '0;
      if (granted) begin
         case (tgt)
            TGT_RAM:    rd_val = ram_cpu_val;
            TGT_PAGE:   rd_val = page_q;
            TGT_VSTART, TGT_HSTART, TGT_VSPACE, TGT_HSPACE, TGT_BGCTL, TGT_BANK:
                        rd_val = ctrl_q[ctrl_slot(tgt)];
            default:    rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else begin
         rdata_q <= cpu_rd ? rd_val : '0;
      end
   end

   assign cpu_rdata = rdata_q;
   assign vstart    = ctrl_q[0];
   assign hstart    = ctrl_q[1];
   assign vspace    = ctrl_q[2];
   assign hspace    = ctrl_q[3];
   assign bgctl     = ctrl_q[4];
   assign charbank  = ctrl_q[5];
   assign disp_en   = ge_q;

endmodule

// File: rtl/dispacc_checker.sv
module dispacc_checker #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                RAM_AW     = 7,
   parameter int                RAM_DEPTH  = 80,
   parameter int                ZERO_BIT   = 6,
   parameter int                PG_LO_BIT  = 5,
   parameter int                PG_HI_BIT  = 6,
   parameter logic [ADDR_W-1:0] PAGE_ADDR  = 'hE8,
   parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [RAM_AW-1:0] eng_addr,
   input logic [DATA_W-1:0] eng_char,
   input logic [DATA_W-1:0] vstart,
   input logic [DATA_W-1:0] hstart,
   input logic [DATA_W-1:0] vspace,
   input logic [DATA_W-1:0] hspace,
   input logic [DATA_W-1:0] bgctl,
   input logic [DATA_W-1:0] charbank,
   input logic              disp_en,
   input logic [DATA_W-1:0] page_q
);

   localparam logic [RAM_AW:0] LIMIT = (RAM_AW+1)'(RAM_DEPTH);

   // R1: a reset cycle leaves enable and read data cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!disp_en && cpu_rdata == '0 && charbank == '0));

   // R3: no stored character byte ever shows bit 6 set
   a_r3_code_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      eng_char[ZERO_BIT] == 1'b0);

   // R7: enable writes land regardless of the current enable value
   a_r7_enable_any_time: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ENABLE_ADDR && page_q[PG_HI_BIT] && !page_q[PG_LO_BIT])
      |=> disp_en == $past(cpu_wdata[0]));

   // R8: protected registers hold while the display is enabled
   a_r8_locked_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en |=> $stable({vstart, hstart, vspace, hspace, bgctl, charbank}));

   // R8: locked reads of anything but the page register give zero
   a_r8_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && cpu_rd && cpu_addr != PAGE_ADDR) |=> cpu_rdata == '0);

   // R9: no read strobe, no read data
   a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> cpu_rdata == '0);

   // R10: engine indexes past the storage read zero
   a_r10_engine_oob: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, eng_addr} >= LIMIT) |-> eng_char == '0);

endmodule

bind dispacc_top dispacc_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .RAM_AW     (RAM_AW),
   .RAM_DEPTH  (WIN_DEPTH + HI_RAM),
   .ZERO_BIT   (ZERO_BIT),
   .PG_LO_BIT  (PG_LO_BIT),
   .PG_HI_BIT  (PG_HI_BIT),
   .PAGE_ADDR  (PAGE_ADDR),
   .ENABLE_ADDR(ADDR_W'(OFS_ENABLE))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .cpu_wdata (cpu_wdata),
   .cpu_rdata (cpu_rdata),
   .eng_addr  (eng_addr),
   .eng_char  (eng_char),
   .vstart    (vstart),
   .hstart    (hstart),
   .vspace    (vspace),
   .hspace    (hspace),
   .bgctl     (bgctl),
   .charbank  (charbank),
   .disp_en   (disp_en),
   .page_q    (page_q)
);

// File: tb/dispacc_top_test.sv
module dispacc_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_addr = '0;
   logic       cpu_wr = 1'b0;
   logic       cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic [6:0] eng_addr = '0;
   logic [7:0] eng_char;
   logic [7:0] vstart, hstart, vspace, hspace, bgctl, charbank;
   logic       disp_en;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   logic [7:0] exp_ram [80];
   logic [7:0] exp_reg [6];   // vstart, hstart, vspace, hspace, bgctl, bank

   always #2 clk = ~clk;   // 250 MHz

   dispacc_top uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .eng_addr(eng_addr), .eng_char(eng_char), .vstart(vstart),
      .hstart(hstart), .vspace(vspace), .hspace(hspace), .bgctl(bgctl),
      .charbank(charbank), .disp_en(disp_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      v = cpu_rdata;
   endtask

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 29 + seed) & 255);
   endfunction

   task automatic engine_sweep(input string req);
      for (int i = 0; i < 128; i++) begin
         eng_addr = 7'(i);
         #1;
         check(req, eng_char, (i < 80) ? exp_ram[i] : 8'h00);
      end
   endtask

   task automatic regs_check(input string req);
      check(req, vstart, exp_reg[0]);
      check(req, hstart, exp_reg[1]);
      check(req, vspace, exp_reg[2]);
      check(req, hspace, exp_reg[3]);
      check(req, bgctl, exp_reg[4]);
      check(req, charbank, exp_reg[5]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      for (int i = 0; i < 80; i++) exp_ram[i] = 8'h00;
      for (int k = 0; k < 6; k++) exp_reg[k] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything clear after reset
      check("R1 disp_en", {7'b0, disp_en}, 8'h00);
      check("R1 rdata", cpu_rdata, 8'h00);
      regs_check("R1 regs");
      engine_sweep("R1 ram");
      rd(8'hE8, v); check("R1 page", v, 8'h00);

      // R6: page register read/write
      wr(8'hE8, 8'h20);
      rd(8'hE8, v); check("R6 page readback", v, 8'h20);

      // R2/R3: page 5 maps the low 64 bytes
      for (int i = 0; i < 64; i++) begin
         wr(8'(i), pat(i, 5));
         exp_ram[i] = pat(i, 5) & 8'hBF;
      end
      for (int i = 0; i < 64; i++) begin
         rd(8'(i), v); check("R2 R3 page5 read", v, exp_ram[i]);
      end

      // R2: page 6 maps the upper 16 bytes
      wr(8'hE8, 8'h40);
      for (int i = 0; i < 16; i++) begin
         wr(8'(i), pat(i, 77));
         exp_ram[64 + i] = pat(i, 77) & 8'hBF;
      end
      for (int i = 0; i < 16; i++) begin
         rd(8'(i), v); check("R2 R3 page6 read", v, exp_ram[64 + i]);
      end
      engine_sweep("R10 engine port");

      // R4: control registers on page 6
      for (int k = 0; k < 5; k++) begin
         wr(8'(16 + k), 8'(8'hC3 ^ (k * 17)));
         exp_reg[k] = 8'(8'hC3 ^ (k * 17));
      end
      for (int k = 0; k < 5; k++) begin
         rd(8'(16 + k), v); check("R4 ctrl read", v, exp_reg[k]);
      end
      regs_check("R4 ctrl outputs");

      // R5: bank register under every page setting
      wr(8'hED, 8'h9E); exp_reg[5] = 8'h9E;
      wr(8'hE8, 8'h00);
      rd(8'hED, v); check("R5 bank no page", v, 8'h9E);
      wr(8'hE8, 8'h60);
      wr(8'hED, 8'hD1); exp_reg[5] = 8'hD1;
      rd(8'hED, v); check("R5 bank both pages", v, 8'hD1);
      check("R5 bank output", charbank, 8'hD1);

      // R6: page setting 60h and 00h reach nothing in the window
      for (int p = 0; p < 2; p++) begin
         wr(8'hE8, (p == 0) ? 8'h60 : 8'h00);
         for (int a = 0; a < 64; a++) begin
            wr(8'(a), 8'hFF);
            rd(8'(a), v); check("R6 no page read", v, 8'h00);
         end
         engine_sweep("R6 no page ram");
         regs_check("R6 no page regs");
      end

      // R9: unmapped page 6 offsets and addresses outside the window
      wr(8'hE8, 8'h40);
      for (int a = 21; a < 64; a++) begin
         if (a != 23) begin
            wr(8'(a), 8'hFF);
            rd(8'(a), v); check("R9 unmapped read", v, 8'h00);
         end
      end
      for (int a = 64; a < 256; a += 7) begin
         if (a != 8'hE8 && a != 8'hED) begin
            wr(8'(a), 8'hFF);
            rd(8'(a), v); check("R9 outside read", v, 8'h00);
         end
      end
      check("R9 enable untouched", {7'b0, disp_en}, 8'h00);
      engine_sweep("R9 ram intact");
      regs_check("R9 regs intact");

      // R7: enable keeps only bit 0 and reads zero
      wr(8'h17, 8'hFE);
      check("R7 upper bits ignored", {7'b0, disp_en}, 8'h00);
      wr(8'h17, 8'h01);
      check("R7 enable set", {7'b0, disp_en}, 8'h01);
      rd(8'h17, v); check("R7 write-only read", v, 8'h00);

      // R8: locked accesses
      for (int i = 0; i < 16; i++) begin
         wr(8'(i), 8'h3C);
         rd(8'(i), v); check("R8 locked ram read p6", v, 8'h00);
      end
      for (int k = 0; k < 5; k++) begin
         wr(8'(16 + k), 8'h55);
         rd(8'(16 + k), v); check("R8 locked ctrl read", v, 8'h00);
      end
      wr(8'hED, 8'h55);
      rd(8'hED, v); check("R8 locked bank read", v, 8'h00);
      wr(8'hE8, 8'h20);
      rd(8'hE8, v); check("R6 page usable while locked", v, 8'h20);
      for (int i = 0; i < 64; i++) begin
         wr(8'(i), 8'h3C);
         rd(8'(i), v); check("R8 locked ram read p5", v, 8'h00);
      end
      engine_sweep("R8 ram intact");
      regs_check("R8 regs intact");

      // R7: enable rewritten while set, then cleared
      wr(8'hE8, 8'h40);
      wr(8'h17, 8'h01);
      check("R7 rewrite while set", {7'b0, disp_en}, 8'h01);
      wr(8'h17, 8'h80);
      check("R7 clear while set", {7'b0, disp_en}, 8'h00);
      rd(8'h05, v); check("R2 access restored", v, exp_ram[64 + 5]);
      wr(8'h14, 8'h7A); exp_reg[4] = 8'h7A;
      check("R4 write restored", bgctl, 8'h7A);
      wr(8'h03, 8'hFF); exp_ram[67] = 8'hBF;
      eng_addr = 7'd67; #1;
      check("R3 bit6 forced", eng_char, 8'hBF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule